// File: doc/BRIEF.md
# Delegating Prioritized Interrupt Selector

This combinational block decides which interrupt a hart should take, if any, and at which privilege level the handler runs. It receives the pending and enable vectors, the two delegation masks, the current privilege, and the three per-level global interrupt-enable bits. Parameters describe whether the hart has user mode, supervisor mode and user-level interrupt support.

Masking and delegation are resolved one level at a time, starting at machine level and moving down. At each level the block forms a pending set and a delegated set. A level that is enabled and has a nonzero pending set keeps the interrupt. If it does not keep it, a nonzero delegated set moves down one level. Any level above the current privilege counts as enabled, and any level below it counts as blocked. Only after one level has claimed a set does a fixed nine-way priority pick a single cause from that set. In a hart with only machine mode, or with no supervisor mode and no user-level interrupts, delegation is skipped.

Privilege encoding on all ports: user = 2'b00, supervisor = 2'b01, machine = 2'b11.

Top module: `irq_route_sel`

## Requirements
- R1: Within the set selected for handling, the nine sources are ranked highest first, as bit position / cause code: machine external 11, machine software 3, machine timer 7, supervisor external 9, supervisor software 1, supervisor timer 5, user external 8, user software 0, user timer 4. `cause_o` carries the bit index of the winner.
- R2: The machine-level pending set is `irq_pend_i & irq_en_i & ~m_dlg_i`. Machine level is enabled when the current privilege is not machine, or when it is machine and `m_gie_i` is 1. A taken interrupt from this level reports target 2'b11.
- R3: The supervisor level exists only when HAS_S=1. Its input is the machine-delegated set `irq_pend_i & m_dlg_i`, and its pending set is that input `& irq_en_i & ~s_dlg_i`. It is enabled when the current privilege is user, or when it is supervisor and `s_gie_i` is 1. A taken interrupt from it reports target 2'b01.
- R4: The user level is enabled only when HAS_N=1, the current privilege is user and `u_gie_i` is 1. It receives the set delegated to it (`ip & deleg`, without the enable mask) and reports target 2'b00.
- R5: A nonzero enabled pending set at a higher level wins over any source delegated lower, even one of higher rank.
- R6: A level that does not take its pending set passes down only its nonzero delegated set. A set delegated to a disabled level yields no interrupt, and nothing falls back upward.
- R7: With HAS_S=0 and HAS_N=1, the machine-delegated set goes straight to user level, and `s_dlg_i` has no effect.
- R8: When HAS_U=0, or when both HAS_S=0 and HAS_N=0, `irq_pend_i & irq_en_i` is ranked directly to machine level. In that case the delegation masks and the global enables have no effect.
- R9: If `irq_pend_i & irq_en_i` is zero, `take_o` is 0, whatever the delegation would otherwise give.
- R10: A selected set holding none of the nine ranked bits yields `take_o`=0. Whenever `take_o` is 0, `cause_o` and `tgt_priv_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irq_pend_i | input | IRQ_W | Pending interrupt vector |
| irq_en_i | input | IRQ_W | Interrupt enable vector |
| m_dlg_i | input | IRQ_W | Machine-to-lower delegation mask |
| s_dlg_i | input | IRQ_W | Supervisor-to-user delegation mask |
| cur_priv_i | input | 2 | Current privilege |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| u_gie_i | input | 1 | User global interrupt enable |
| take_o | output | 1 | An interrupt is to be taken |
| cause_o | output | $clog2(IRQ_W) | Cause code of the chosen interrupt |
| tgt_priv_o | output | 2 | Privilege that handles it |

## Verification
The bench drives the same inputs into three builds at once. The first is the full three-level build (HAS_U=1, HAS_S=1, HAS_N=1); it reaches the supervisor stage and the enable rules that depend on privilege. The second is HAS_S=0, HAS_N=1, where machine-delegated bits land directly at user level and the supervisor mask must have no effect. The third is HAS_S=0, HAS_N=0, where the flat path ignores the delegation masks and the global enables. Together these show that level order beats rank and that nothing falls back upward.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam int unsigned N_RANK = 9;
  localparam int unsigned MIN_W  = 12;

  // bit positions, highest priority first
  localparam int unsigned RANK_POS [N_RANK] = '{11, 3, 7, 9, 1, 5, 8, 0, 4};
endpackage

// File: rtl/irq_level.sv
module irq_level #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] ip_i,
  input  logic [W-1:0] ie_i,
  input  logic [W-1:0] dlg_i,
  input  logic         en_i,
  output logic         take_o,
  output logic         pass_o,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] fwd_o
);
  assign pend_o = ip_i & ie_i & ~dlg_i;
  assign fwd_o  = ip_i & dlg_i;
  assign take_o = en_i && (|pend_o);
  assign pass_o = !take_o && (|fwd_o);
endmodule

// File: rtl/irq_rank_enc.sv
module irq_rank_enc
  import irq_route_pkg::*;
#(
  parameter int unsigned W  = 12,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  set_i,
  output logic          hit_o,
  output logic [CW-1:0] idx_o
);
  logic [N_RANK-1:0] ranked;

  for (genvar r = 0; r < N_RANK; r++) begin : g_rank
    assign ranked[r] = set_i[RANK_POS[r]];
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int r = N_RANK - 1; r >= 0; r--) begin
      if (ranked[r]) begin
        hit_o = 1'b1;
        idx_o = CW'(RANK_POS[r]);
      end
    end
  end
endmodule

// File: rtl/irq_route_sel.sv
module irq_route_sel
  import irq_route_pkg::*;
#(
  parameter int unsigned IRQ_W = 12,
  parameter bit          HAS_U = 1'b1,
  parameter bit          HAS_S = 1'b1,
  parameter bit          HAS_N = 1'b1,
  localparam int unsigned CW   = $clog2(IRQ_W)
) (
  input  logic [IRQ_W-1:0] irq_pend_i,
  input  logic [IRQ_W-1:0] irq_en_i,
  input  logic [IRQ_W-1:0] m_dlg_i,
  input  logic [IRQ_W-1:0] s_dlg_i,
  input  logic [1:0]       cur_priv_i,
  input  logic             m_gie_i,
  input  logic             s_gie_i,
  input  logic             u_gie_i,
  output logic             take_o,
  output logic [CW-1:0]    cause_o,
  output logic [1:0]       tgt_priv_o
);
  localparam bit FLAT = !HAS_U || (!HAS_S && !HAS_N);

  logic             m_en, s_en, u_en;
  logic             m_take, m_pass, s_take, s_pass;
  logic [IRQ_W-1:0] m_pend, m_fwd, s_pend, s_fwd;
  logic [IRQ_W-1:0] eff, sel;
  logic [1:0]       tgt_raw;
  logic             hit;
  logic [CW-1:0]    idx;

  assign eff  = irq_pend_i & irq_en_i;
  // higher levels implicitly enabled, lower blocked
  assign m_en = (cur_priv_i != PRIV_M) || m_gie_i;
  assign s_en = HAS_S && ((cur_priv_i == PRIV_U) || ((cur_priv_i == PRIV_S) && s_gie_i));
  assign u_en = HAS_N && (cur_priv_i == PRIV_U) && u_gie_i;

  irq_level #(.W(IRQ_W)) u_m_lvl (
    .ip_i  (irq_pend_i),
    .ie_i  (irq_en_i),
    .dlg_i (m_dlg_i),
    .en_i  (m_en),
    .take_o(m_take),
    .pass_o(m_pass),
    .pend_o(m_pend),
    .fwd_o (m_fwd)
  );

  if (HAS_S) begin : g_s_lvl
    irq_level #(.W(IRQ_W)) u_s_lvl (
      .ip_i  (m_fwd),
      .ie_i  (irq_en_i),
      .dlg_i (s_dlg_i),
      .en_i  (s_en),
      .take_o(s_take),
      .pass_o(s_pass),
      .pend_o(s_pend),
      .fwd_o (s_fwd)
    );
  end else begin : g_no_s
    // machine-delegated bits bypass straight to user level
    assign s_take = 1'b0;
    assign s_pass = m_pass;
    assign s_pend = '0;
    assign s_fwd  = m_fwd;
  end

  always_comb begin
    sel     = '0;
    tgt_raw = PRIV_M;
    if (eff == '0) begin
      sel = '0;
    end else if (FLAT) begin
      sel = eff;
    end else if (m_take) begin
      sel = m_pend;
    end else if (s_take) begin
      sel     = s_pend;
      tgt_raw = PRIV_S;
    end else if (s_pass && u_en) begin
      sel     = s_fwd;
      tgt_raw = PRIV_U;
    end
  end

  irq_rank_enc #(.W(IRQ_W)) u_rank (
    .set_i(sel),
    .hit_o(hit),
    .idx_o(idx)
  );

  assign take_o     = hit;
  assign cause_o    = hit ? idx : '0;
  assign tgt_priv_o = hit ? tgt_raw : PRIV_U;

  always_comb begin
    a_r9_fast_path: assert (eff != '0 || !take_o);
    a_r1_cause_pending: assert (!take_o || irq_pend_i[cause_o]);
    a_r2_m_enabled_src: assert (!(take_o && tgt_priv_o == PRIV_M) || irq_en_i[cause_o]);
    a_r3_s_route: assert (!(take_o && tgt_priv_o == PRIV_S)
                          || (HAS_S && m_dlg_i[cause_o] && !s_dlg_i[cause_o]
                              && cur_priv_i != PRIV_M));
    a_r4_u_gate: assert (!(take_o && tgt_priv_o == PRIV_U)
                         || (HAS_N && cur_priv_i == PRIV_U && u_gie_i));
    a_r6_no_lower_tgt: assert (!take_o || FLAT || tgt_priv_o >= cur_priv_i);
    a_r10_idle_zero: assert (take_o || (cause_o == '0 && tgt_priv_o == PRIV_U));
  end
endmodule

// File: tb/irq_route_sel_test.sv
module irq_route_sel_test;
  localparam int W = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [W-1:0] pend = '0, en = '0, mdl = '0, sdl = '0;
  logic [1:0]   priv = 2'b11;
  logic         mg = 1'b0, sg = 1'b0, ug = 1'b0;

  logic       f_take, n_take, z_take;
  logic [3:0] f_cause, n_cause, z_cause;
  logic [1:0] f_tgt, n_tgt, z_tgt;

  int total = 0;
  int bad   = 0;

  irq_route_sel #(.IRQ_W(W)) uut (
    .irq_pend_i(pend), .irq_en_i(en), .m_dlg_i(mdl), .s_dlg_i(sdl),
    .cur_priv_i(priv), .m_gie_i(mg), .s_gie_i(sg), .u_gie_i(ug),
    .take_o(f_take), .cause_o(f_cause), .tgt_priv_o(f_tgt));

  irq_route_sel #(.IRQ_W(W), .HAS_S(1'b0), .HAS_N(1'b1)) uut_nos (
    .irq_pend_i(pend), .irq_en_i(en), .m_dlg_i(mdl), .s_dlg_i(sdl),
    .cur_priv_i(priv), .m_gie_i(mg), .s_gie_i(sg), .u_gie_i(ug),
    .take_o(n_take), .cause_o(n_cause), .tgt_priv_o(n_tgt));

  irq_route_sel #(.IRQ_W(W), .HAS_S(1'b0), .HAS_N(1'b0)) uut_flat (
    .irq_pend_i(pend), .irq_en_i(en), .m_dlg_i(mdl), .s_dlg_i(sdl),
    .cur_priv_i(priv), .m_gie_i(mg), .s_gie_i(sg), .u_gie_i(ug),
    .take_o(z_take), .cause_o(z_cause), .tgt_priv_o(z_tgt));

  typedef struct packed {
    logic [3:0]   rq;
    logic [W-1:0] p, e, md, sd;
    logic [1:0]   pv;
    logic         m, s, u;
    logic         xv;
    logic [3:0]   xc;
    logic [1:0]   xp;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{4'd9,  12'h000, 12'h000, 12'h000, 12'h000, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  2'b00}, // R9 idle
    '{4'd1,  12'h888, 12'hFFF, 12'h000, 12'h000, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 4'd11, 2'b11}, // R1
    '{4'd1,  12'h088, 12'hFFF, 12'h000, 12'h000, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3,  2'b11}, // R1
    '{4'd1,  12'h080, 12'hFFF, 12'h000, 12'h000, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7,  2'b11}, // R1
    '{4'd1,  12'h222, 12'hFFF, 12'h000, 12'h000, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 4'd9,  2'b11}, // R1
    '{4'd1,  12'h111, 12'hFFF, 12'h000, 12'h000, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8,  2'b11}, // R1
    '{4'd1,  12'h011, 12'hFFF, 12'h000, 12'h000, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  2'b11}, // R1
    '{4'd1,  12'h010, 12'hFFF, 12'h000, 12'h000, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4,  2'b11}, // R1
    '{4'd1,  12'h022, 12'hFFF, 12'h000, 12'h000, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1,  2'b11}, // R1
    '{4'd2,  12'h800, 12'hFFF, 12'h000, 12'h000, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'b00}, // R2
    '{4'd2,  12'h800, 12'hFFF, 12'h000, 12'h000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 4'd11, 2'b11}, // R2
    '{4'd9,  12'h800, 12'h7FF, 12'h000, 12'h000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'b00}, // R9
    '{4'd3,  12'h222, 12'hFFF, 12'h222, 12'h000, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 4'd9,  2'b01}, // R3
    '{4'd6,  12'h222, 12'hFFF, 12'h222, 12'h000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'b00}, // R6
    '{4'd3,  12'h222, 12'hFFF, 12'h222, 12'h000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9,  2'b01}, // R3
    '{4'd6,  12'h222, 12'hFFF, 12'h222, 12'h000, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  2'b00}, // R6
    '{4'd5,  12'h022, 12'hFFF, 12'h020, 12'h000, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1,  2'b11}, // R5
    '{4'd4,  12'h111, 12'h111, 12'h111, 12'h111, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8,  2'b00}, // R4
    '{4'd4,  12'h111, 12'h111, 12'h111, 12'h111, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  2'b00}, // R4
    '{4'd6,  12'h111, 12'h111, 12'h111, 12'h111, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0,  2'b00}, // R6
    '{4'd9,  12'h111, 12'h000, 12'h111, 12'h111, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0,  2'b00}, // R9
    '{4'd4,  12'h110, 12'h010, 12'h110, 12'h110, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8,  2'b00}, // R4
    '{4'd5,  12'h012, 12'hFFF, 12'h012, 12'h010, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1,  2'b01}  // R5
  };

  task automatic apply(input logic [W-1:0] p, e, md, sd, input logic [1:0] pv,
                       input logic m, s, u);
    @(posedge clk);
    pend = p; en = e; mdl = md; sdl = sd; priv = pv; mg = m; sg = s; ug = u;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic av, input logic [3:0] ac,
                     input logic [1:0] ap, input logic xv, input logic [3:0] xc,
                     input logic [1:0] xp);
    total++;
    if (av !== xv || ac !== xc || ap !== xp) begin
      bad++;
      $display("FAIL %s: got take=%0b cause=%0d tgt=%0d, want take=%0b cause=%0d tgt=%0d",
               tag, av, ac, ap, xv, xc, xp);
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("timeout: run hung");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    string tg;
    @(negedge clk);
    chk("R10 idle outputs", f_take, f_cause, f_tgt, 1'b0, 4'd0, 2'b00);

    foreach (TBL[i]) begin
      apply(TBL[i].p, TBL[i].e, TBL[i].md, TBL[i].sd, TBL[i].pv, TBL[i].m, TBL[i].s, TBL[i].u);
      tg = $sformatf("R%0d vec %0d", TBL[i].rq, i);
      chk(tg, f_take, f_cause, f_tgt, TBL[i].xv, TBL[i].xc, TBL[i].xp);
    end

    // R10: unranked bit selected at machine level
    apply(12'h004, 12'hFFF, 12'h000, 12'h000, 2'b11, 1'b1, 1'b0, 1'b0);
    chk("R10 unranked", f_take, f_cause, f_tgt, 1'b0, 4'd0, 2'b00);

    // R7: no supervisor level, delegated bits go to user
    apply(12'h111, 12'h111, 12'h111, 12'h000, 2'b00, 1'b0, 1'b0, 1'b1);
    chk("R7 bypass to user", n_take, n_cause, n_tgt, 1'b1, 4'd8, 2'b00);
    chk("R8 flat ignores delegation", z_take, z_cause, z_tgt, 1'b1, 4'd8, 2'b11);
    apply(12'h111, 12'h111, 12'h111, 12'hFFF, 2'b00, 1'b0, 1'b0, 1'b1);
    chk("R7 s mask no effect", n_take, n_cause, n_tgt, 1'b1, 4'd8, 2'b00);
    apply(12'h200, 12'hFFF, 12'h200, 12'h000, 2'b00, 1'b0, 1'b0, 1'b1);
    chk("R7 s-ext to user", n_take, n_cause, n_tgt, 1'b1, 4'd9, 2'b00);
    apply(12'h111, 12'h111, 12'h111, 12'h000, 2'b00, 1'b0, 1'b0, 1'b0);
    chk("R7 user disabled", n_take, n_cause, n_tgt, 1'b0, 4'd0, 2'b00);

    // R8: flat path ignores global enable and delegation
    apply(12'h888, 12'h080, 12'hFFF, 12'h000, 2'b11, 1'b0, 1'b0, 1'b0);
    chk("R8 flat mie off", z_take, z_cause, z_tgt, 1'b1, 4'd7, 2'b11);
    chk("R2 nos delegated all", n_take, n_cause, n_tgt, 1'b0, 4'd0, 2'b00);
    apply(12'h888, 12'h000, 12'h000, 12'h000, 2'b11, 1'b1, 1'b0, 1'b0);
    chk("R9 flat fast path", z_take, z_cause, z_tgt, 1'b0, 4'd0, 2'b00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule